// File: doc/BRIEF.md
# Burst-Based Phase Change Predictor

The block predicts the phase ID of the next fixed-length execution interval. When each interval ends, the phase ID it was classified into is presented on `id_i` with `id_valid_i` high. The block tracks the IDs of the most recent phase bursts and how many intervals the current burst has lasted. From the burst history it forms a hash, and the hash selects and tags one entry of a direct-mapped table. Each entry has learned two things: how long the burst lasts, and which phase comes next.

One saturating counter per entry serves two purposes. It enables a phase change prediction only while the entry has proven reliable. It also keeps a reliable entry from being overwritten by a single irregular burst. When no confident prediction exists, the block predicts that the current phase continues. A system that adapts hardware to the program's phases uses the predicted ID to prepare for the interval ahead.

Top module: `phase_predictor`

## Requirements
- R1: After reset `pred_valid_o` is low. The first accepted ID after reset yields a prediction equal to that ID.
- R2: `pred_valid_o` is high in the cycle after each cycle with `id_valid_i` high, and low after a cycle without it. `pred_id_o` is meaningful while `pred_valid_o` is high.
- R3: On a table miss, or on a hit whose counter is not above `CONF_THR`, the prediction is the most recently accepted ID.
- R4: History slot i holds the ID of the i-th most recent burst, where slot 0 is the current burst. The slot is shifted left by floor(i*(H-P)/(N-1)) bits, with H = IDX_W+TAG_W and P = P_W, and the shifted slots are XORed. Bits [IDX_W-1:0] of the result index the table, and the upper TAG_W bits are the tag.
- R5: On a phase change that misses, the entry addressed by the old history is written with valid, tag, the observed burst length, the new ID and a counter of zero. On any phase change, the new ID is pushed into the history and the run count restarts at 1.
- R6: While an entry hits, every accepted ID steps the entry's counter. The counter goes up by one (saturating at all ones) if the entry's raw guess equals the ID, and down by one (saturating at zero) otherwise. The raw guess is the stored next ID when the run count equals a nonzero stored length, and the current ID otherwise.
- R7: If the entry hits and its counter exceeds `CONF_THR`, the block predicts the stored next ID. This happens only once the current burst has lasted exactly the stored length and that length is nonzero.
- R8: A phase change that hits an entry rewrites the entry's length and next ID only if its counter was zero before the update.
- R9: A burst longer than 2^RUN_W-1 intervals is stored with length 0. A length of 0 never produces a change prediction.
- R10: Cycles with `id_valid_i` low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | An interval has ended and `id_i` holds its phase ID |
| id_i | input | P_W | Actual phase ID of the interval that ended |
| pred_valid_o | output | 1 | A new prediction is available |
| pred_id_o | output | P_W | Predicted phase ID of the next interval |

## Verification
The assertions assume that `id_i` carries a defined value in every cycle where `id_valid_i` is high. They also assume that the block sees at most one interval per cycle. The bench drives `id_i` only together with `id_valid_i` and holds it at known values otherwise. Some stretches have idle gaps between intervals, so held state can be compared against the reference model. The stimulus mixes regular burst patterns, a single noisy burst, bursts longer than the length field, and random bursts over several ID alphabets.

// File: rtl/phase_pkg.sv
package phase_pkg;
  // left shift applied to history slot i when folding into the hash
  function automatic int hash_shift(int i, int n, int h_w, int p_w);
    if (n <= 1) return 0;
    return (i * (h_w - p_w)) / (n - 1);
  endfunction
endpackage

// File: rtl/phase_hist.sv
module phase_hist #(
  parameter int P_W   = 4,
  parameter int N_LVL = 2,
  parameter int RUN_W = 4,
  parameter int H_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [P_W-1:0]   id_i,
  output logic             started_o,
  output logic             chg_o,
  output logic [P_W-1:0]   cur_id_o,
  output logic [RUN_W-1:0] run_len_o,
  output logic             run_long_o,
  output logic [H_W-1:0]   hash_o
);
  logic [N_LVL-1:0][P_W-1:0] hist_q;
  logic [N_LVL-1:0][H_W-1:0] part;
  logic                      started_q, long_q;
  logic [RUN_W-1:0]          run_q;

  assign chg_o      = acc_i & started_q & (id_i != hist_q[0]);
  assign started_o  = started_q;
  assign cur_id_o   = hist_q[0];
  assign run_len_o  = run_q;
  assign run_long_o = long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q    <= '0;
      started_q <= 1'b0;
      run_q     <= '0;
      long_q    <= 1'b0;
    end else if (acc_i) begin
      if (!started_q) begin
        started_q <= 1'b1;
        hist_q[0] <= id_i;
        run_q     <= RUN_W'(1);
        long_q    <= 1'b0;
      end else if (chg_o) begin
        for (int i = N_LVL - 1; i > 0; i--) hist_q[i] <= hist_q[i-1];
        hist_q[0] <= id_i;
        run_q     <= RUN_W'(1);
        long_q    <= 1'b0;
      end else if (run_q == '1) begin
        long_q <= 1'b1;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  for (genvar g = 0; g < N_LVL; g++) begin : g_fold
    localparam int SH = phase_pkg::hash_shift(g, N_LVL, H_W, P_W);
    assign part[g] = H_W'(hist_q[g]) << SH;
  end

  always_comb begin
    hash_o = '0;
    for (int i = 0; i < N_LVL; i++) hash_o ^= part[i];
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(hist_q[0]) && $stable(run_q) && $stable(long_q));
  a_r9_run_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> run_q != '0);
endmodule

// File: rtl/phase_table.sv
module phase_table #(
  parameter int P_W      = 4,
  parameter int RUN_W    = 4,
  parameter int CNT_W    = 2,
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 4,
  parameter int CONF_THR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             started_i,
  input  logic             chg_i,
  input  logic [P_W-1:0]   id_i,
  input  logic [P_W-1:0]   cur_id_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic             run_long_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [P_W-1:0]   pred_id_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0][RUN_W-1:0] len_q;
  logic [DEPTH-1:0][P_W-1:0]   nxt_q;
  logic [DEPTH-1:0][CNT_W-1:0] ctr_q;

  logic             hit, guess_chg, confident, upd;
  logic [P_W-1:0]   guess;
  logic [RUN_W-1:0] obs_len;
  logic [CNT_W-1:0] ctr_cur;

  assign ctr_cur   = ctr_q[idx_i];
  assign hit       = vld_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign guess_chg = hit && !run_long_i && (len_q[idx_i] != '0) && (run_len_i == len_q[idx_i]);
  assign guess     = guess_chg ? nxt_q[idx_i] : cur_id_i;
  assign confident = int'(ctr_cur) > CONF_THR;
  assign pred_id_o = (guess_chg && confident) ? nxt_q[idx_i] : cur_id_i;
  assign upd       = acc_i & started_i;
  assign obs_len   = run_long_i ? '0 : run_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
      len_q <= '0;
      nxt_q <= '0;
      ctr_q <= '0;
    end else if (upd) begin
      if (hit) begin
        if (guess == id_i) begin
          if (ctr_cur != '1) ctr_q[idx_i] <= ctr_cur + CNT_W'(1);
        end else if (ctr_cur != '0) begin
          ctr_q[idx_i] <= ctr_cur - CNT_W'(1);
        end
      end
      if (chg_i) begin
        if (!hit) begin
          vld_q[idx_i] <= 1'b1;
          tag_q[idx_i] <= tag_i;
          len_q[idx_i] <= obs_len;
          nxt_q[idx_i] <= id_i;
          ctr_q[idx_i] <= '0;
        end else if (ctr_cur == '0) begin
          len_q[idx_i] <= obs_len;
          nxt_q[idx_i] <= id_i;
        end
      end
    end
  end

  a_r6_ctr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && hit |=> (int'(ctr_q[$past(idx_i)]) - int'($past(ctr_cur)) <= 1) &&
                   (int'($past(ctr_cur)) - int'(ctr_q[$past(idx_i)]) <= 1));
  a_r8_keep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && chg_i && hit && ctr_cur != '0 |=>
      len_q[$past(idx_i)] == $past(len_q[idx_i]) && nxt_q[$past(idx_i)] == $past(nxt_q[idx_i]));
  a_r5_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && chg_i && !hit |=> vld_q[$past(idx_i)] && ctr_q[$past(idx_i)] == '0);
endmodule

// File: rtl/phase_predictor.sv
module phase_predictor #(
  parameter int P_W      = 4,
  parameter int N_LVL    = 2,
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 4,
  parameter int RUN_W    = 4,
  parameter int CNT_W    = 2,
  parameter int CONF_THR = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           id_valid_i,
  input  logic [P_W-1:0] id_i,
  output logic           pred_valid_o,
  output logic [P_W-1:0] pred_id_o
);
  localparam int H_W = IDX_W + TAG_W;

  logic             started, chg, run_long;
  logic [P_W-1:0]   cur_id;
  logic [RUN_W-1:0] run_len;
  logic [H_W-1:0]   hash;
  logic             vld_q;

  phase_hist #(.P_W(P_W), .N_LVL(N_LVL), .RUN_W(RUN_W), .H_W(H_W)) hist_i (
    .clk_i, .rst_ni, .acc_i(id_valid_i), .id_i,
    .started_o(started), .chg_o(chg), .cur_id_o(cur_id),
    .run_len_o(run_len), .run_long_o(run_long), .hash_o(hash)
  );

  phase_table #(.P_W(P_W), .RUN_W(RUN_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
                .TAG_W(TAG_W), .CONF_THR(CONF_THR)) table_i (
    .clk_i, .rst_ni, .acc_i(id_valid_i), .started_i(started), .chg_i(chg),
    .id_i, .cur_id_i(cur_id), .run_len_i(run_len), .run_long_i(run_long),
    .idx_i(hash[IDX_W-1:0]), .tag_i(hash[H_W-1:IDX_W]), .pred_id_o(pred_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= id_valid_i;
  end
  assign pred_valid_o = vld_q;

  a_r2_valid_after_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_i |=> pred_valid_o);
  a_r2_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |=> !pred_valid_o);
endmodule

// File: tb/phase_predictor_tb_top.sv
module phase_predictor_tb_top;
  localparam int P_W = 4, N_LVL = 2, IDX_W = 4, TAG_W = 4, RUN_W = 4, CNT_W = 2, CONF_THR = 1;
  localparam int H_W = IDX_W + TAG_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int RMAX = (1 << RUN_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, id_valid_i = 1'b0;
  logic [P_W-1:0] id_i = '0;
  logic pred_valid_o;
  logic [P_W-1:0] pred_id_o;

  phase_predictor dut_i (.clk_i(clk), .rst_ni, .id_valid_i, .id_i, .pred_valid_o, .pred_id_o);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string ph = "R3";

  // reference model
  bit m_started;
  int m_hist[N_LVL];
  int m_run;
  bit m_long;
  bit m_vld[DEPTH];
  int m_tag[DEPTH], m_len[DEPTH], m_nxt[DEPTH], m_ctr[DEPTH];

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int m_hash();
    int h = 0;
    for (int i = 0; i < N_LVL; i++) begin
      int sh = (N_LVL > 1) ? (i * (H_W - P_W)) / (N_LVL - 1) : 0;
      h ^= (m_hist[i] << sh);
    end
    return h & ((1 << H_W) - 1);
  endfunction

  function automatic bit m_hit(int h);
    int ix = h % DEPTH;
    return m_vld[ix] && m_tag[ix] == (h / DEPTH);
  endfunction

  function automatic bit m_guess_chg();
    int h = m_hash();
    int ix = h % DEPTH;
    return m_hit(h) && !m_long && m_len[ix] != 0 && m_run == m_len[ix];
  endfunction

  function automatic int m_pred();
    int ix = m_hash() % DEPTH;
    if (m_guess_chg() && m_ctr[ix] > CONF_THR) return m_nxt[ix];
    return m_hist[0];
  endfunction

  task automatic m_step(int x);
    int h = m_hash();
    int ix = h % DEPTH;
    bit hit = m_hit(h);
    int guess = m_guess_chg() ? m_nxt[ix] : m_hist[0];
    int c0 = m_ctr[ix];
    if (!m_started) begin
      m_started = 1; m_hist[0] = x; m_run = 1; m_long = 0;
      return;
    end
    if (hit) begin
      if (guess == x) m_ctr[ix] = (c0 == CMAX) ? c0 : c0 + 1;
      else            m_ctr[ix] = (c0 == 0) ? 0 : c0 - 1;
    end
    if (x != m_hist[0]) begin
      if (!hit) begin
        m_vld[ix] = 1; m_tag[ix] = h / DEPTH; m_len[ix] = m_long ? 0 : m_run;
        m_nxt[ix] = x; m_ctr[ix] = 0;
      end else if (c0 == 0) begin
        m_len[ix] = m_long ? 0 : m_run; m_nxt[ix] = x;
      end
      for (int i = N_LVL - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = x; m_run = 1; m_long = 0;
    end else if (m_run == RMAX) m_long = 1;
    else m_run++;
  endtask

  task automatic send(int x, int gap = 0);
    int e;
    id_valid_i = 1'b1;
    id_i = P_W'(x);
    @(posedge clk);
    m_step(x);
    @(negedge clk);
    id_valid_i = 1'b0;
    id_i = '0;
    e = m_pred();
    chk("R2", int'(pred_valid_o), 1);
    chk((e != m_hist[0]) ? "R7" : ph, int'(pred_id_o), e);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R2", int'(pred_valid_o), 0);
      chk("R10", int'(pred_id_o), e);
    end
  endtask

  task automatic burst(int x, int n, int gap = 0);
    for (int k = 0; k < n; k++) send(x, gap);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N_LVL; i++) m_hist[i] = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 0; m_tag[i] = 0; m_len[i] = 0; m_nxt[i] = 0; m_ctr[i] = 0;
    end
    m_started = 0; m_run = 0; m_long = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(pred_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", int'(pred_valid_o), 0);
    ph = "R1";
    send(3, 1);
    chk("R1", int'(pred_id_o), 3);

    // regular pattern: first round misses, later rounds learn and predict
    ph = "R3";
    burst(3, 2); burst(5, 2); burst(9, 1);
    ph = "R5";
    for (int r = 0; r < 8; r++) begin burst(3, 3); burst(5, 2); burst(9, 1); end

    // one noisy burst inside a trained pattern
    ph = "R8";
    burst(3, 4); burst(5, 2); burst(9, 1);
    for (int r = 0; r < 6; r++) begin burst(3, 3); burst(5, 2); burst(9, 1); end

    // bursts longer than the length field
    ph = "R9";
    for (int r = 0; r < 4; r++) begin burst(7, 20); burst(2, 1); end

    // idle gaps between intervals
    ph = "R10";
    for (int r = 0; r < 40; r++) burst(1 + (r % 3), 1 + (r % 2), $urandom_range(0, 3));

    // random bursts over a small alphabet
    ph = "R6";
    for (int r = 0; r < 400; r++) burst($urandom_range(0, 3), $urandom_range(1, 4));

    // random bursts over the full alphabet, exercising hash aliasing
    ph = "R4";
    for (int r = 0; r < 400; r++) burst($urandom_range(0, (1 << P_W) - 1), $urandom_range(1, 3));

    summary();
  end
endmodule